// File: doc/BRIEF.md
# Multi-width register ALU datapath

This block runs one register-to-register arithmetic or logic operation per clock on a small byte-organised register file, then updates the four condition flags: carry (CY), zero (Z), negative (N) and overflow (OV). Each request has a 4-bit operation code, a 4-bit width code and two 4-bit register indices (destination and source). The width code decides how those indices are read: as one of 16 byte registers, as one of 16 word registers laid over byte pairs, or as a double-word register. The file is big-endian: the byte at the lower address is the most significant byte of a word or double word.

The operation executes on the clock edge that samples `issue_i`. On that edge the block reads both operands, computes the result, writes it back and loads the new flags. Multiply and divide produce a double-width value. They write it to the aligned register pair that holds the destination. Compare only moves the flags. A byte load port fills the file and an asynchronous byte peek port reads it out. Together they give the rest of the core, and the bench, access to the stored values.

Top module: `mw_reg_alu`

## Requirements
- R1: Operation codes are 2 add, 4 OR, 5 AND, 6 XOR, 7 move, 8 divide, 9 subtract, 10 multiply and 11 compare. Width codes are 12 for byte, 13 for word and 15 for double word. Any other operation or width code is an error.
- R2: Byte index i names file byte i. Word index n names bytes 2n (most significant) and 2n+1. Operands are zero-extended unsigned values of the selected width.
- R3: Double-word index k from 0 to 7 names bytes 4k..4k+3. Index 8 names bytes 56..59 (pointer extension) and index 9 names bytes 60..63 (stack pointer). Indices 10 to 15 in either operand are an error.
- R4: Add and subtract write the result truncated to the width. CY is the carry out (add) or borrow (subtract, set when dst < src unsigned). OV is two's-complement overflow. Z is set when the result is zero and N is the result's top bit.
- R5: Compare sets all four flags exactly as a subtract of source from destination, and writes no register.
- R6: AND, OR and XOR write the bitwise result and update Z and N. CY and OV keep their values.
- R7: Move copies the source to the destination and leaves all four flags unchanged.
- R8: Multiply (byte or word width) forms the unsigned double-width product of destination and source. The upper half goes to the even register of the destination's aligned pair and the lower half to the odd register. Z is set when the product is zero, N is the product's top bit, and CY and OV are cleared. A double-word multiply is an error.
- R9: Divide (byte or word width) writes the unsigned quotient of destination by source to the odd register of the aligned pair and the remainder to the even register. Z and N come from the quotient, and CY and OV are cleared. A zero divisor or double-word width is an error.
- R10: `done_o`, `err_o` and the flags are registered. They show a request one cycle after the edge that samples `issue_i`. Register writes are visible on the peek port after that same edge.
- R11: An errored request writes no register and leaves the flags unchanged. It raises `err_o` together with `done_o` for one cycle.
- R12: A load request writes one byte at the given file address on the clock edge. The peek port returns the addressed file byte combinationally. Reset clears the file, the flags, `done_o` and `err_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | Execute the operation given on the request fields |
| op_i | input | 4 | Operation code |
| wid_i | input | 4 | Width code |
| dst_i | input | 4 | Destination register index |
| src_i | input | 4 | Source register index |
| ld_en_i | input | 1 | Byte load strobe |
| ld_addr_i | input | 6 | Byte load address |
| ld_data_i | input | 8 | Byte load data |
| pk_addr_i | input | 6 | Peek address |
| pk_data_o | output | 8 | File byte at the peek address |
| done_o | output | 1 | Request completed (one cycle after issue) |
| err_o | output | 1 | Completed request was rejected |
| cy_o | output | 1 | Carry / borrow flag |
| z_o | output | 1 | Zero flag |
| n_o | output | 1 | Negative flag |
| ov_o | output | 1 | Overflow flag |

## Verification
Every request result is due one edge after issue. `done_o`, `err_o` and the four flags change on the edge that samples `issue_i`, and the register write lands on that same edge. The bench drives a request on a falling edge and drops `issue_i` on the next falling edge. It samples the status outputs at that second falling edge, half a cycle after the executing edge. It then sweeps the whole file through the combinational peek port while no request or load is active. A load likewise becomes visible one edge after its strobe.

// File: rtl/mw_alu_pkg.sv
package mw_alu_pkg;

   localparam int OPC_W  = 4;
   localparam int IDX_W  = 4;
   localparam int BYTE_W = 8;
   localparam int WIN_W  = 4 * BYTE_W;

   localparam logic [OPC_W-1:0] OP_ADD = 4'd2;
   localparam logic [OPC_W-1:0] OP_ORL = 4'd4;
   localparam logic [OPC_W-1:0] OP_ANL = 4'd5;
   localparam logic [OPC_W-1:0] OP_XRL = 4'd6;
   localparam logic [OPC_W-1:0] OP_MOV = 4'd7;
   localparam logic [OPC_W-1:0] OP_DIV = 4'd8;
   localparam logic [OPC_W-1:0] OP_SUB = 4'd9;
   localparam logic [OPC_W-1:0] OP_MUL = 4'd10;
   localparam logic [OPC_W-1:0] OP_CMP = 4'd11;

   localparam logic [OPC_W-1:0] WD_BYTE  = 4'd12;
   localparam logic [OPC_W-1:0] WD_WORD  = 4'd13;
   localparam logic [OPC_W-1:0] WD_DWORD = 4'd15;

   typedef struct packed {
      logic cy;
      logic z;
      logic n;
      logic ov;
   } flags_t;

endpackage

// File: rtl/mw_idx_map.sv
module mw_idx_map
   import mw_alu_pkg::*;
#(
   parameter int ADDR_W   = 6,
   parameter int DPX_BASE = 56,
   parameter int SPX_BASE = 60
) (
   input  logic [OPC_W-1:0]  wid_i,
   input  logic [IDX_W-1:0]  idx_i,
   input  logic              pair_i,
   output logic [ADDR_W-1:0] base_o,
   output logic              ok_o
);

   localparam logic [ADDR_W-1:0] DPX_A = ADDR_W'(DPX_BASE);
   localparam logic [ADDR_W-1:0] SPX_A = ADDR_W'(SPX_BASE);

   logic [ADDR_W-1:0] idx_x;
   logic [ADDR_W-1:0] even_x;

   assign idx_x  = ADDR_W'(idx_i);
   assign even_x = ADDR_W'({idx_i[IDX_W-1:1], 1'b0});

   always_comb begin
      base_o = '0;
      ok_o   = 1'b1;
      case (wid_i)
         WD_BYTE:  base_o = pair_i ? even_x : idx_x;
         WD_WORD:  base_o = pair_i ? (even_x << 1) : (idx_x << 1);
         WD_DWORD: begin
            if (!idx_i[IDX_W-1])
               base_o = idx_x << 2;
            else if (idx_i == 4'd8)
               base_o = DPX_A;
            else if (idx_i == 4'd9)
               base_o = SPX_A;
            else
               ok_o = 1'b0;
         end
         default:  ok_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/mw_regfile.sv
module mw_regfile
   import mw_alu_pkg::*;
#(
   parameter int FILE_BYTES = 64,
   parameter int ADDR_W     = $clog2(FILE_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] rd_a_base_i,
   input  logic [ADDR_W-1:0] rd_b_base_i,
   output logic [WIN_W-1:0]  rd_a_win_o,
   output logic [WIN_W-1:0]  rd_b_win_o,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_base_i,
   input  logic [2:0]        wr_nb_i,
   input  logic [WIN_W-1:0]  wr_data_i,
   input  logic              ld_en_i,
   input  logic [ADDR_W-1:0] ld_addr_i,
   input  logic [BYTE_W-1:0] ld_data_i,
   input  logic [ADDR_W-1:0] pk_addr_i,
   output logic [BYTE_W-1:0] pk_data_o
);

   logic [BYTE_W-1:0] mem_q [FILE_BYTES];
   logic [WIN_W-1:0]  wr_left;

   // left-align the write value so byte 0 of the window is the MSB
   assign wr_left = wr_data_i << ({3'd4 - wr_nb_i, 3'b000});

   genvar gi, gk;
   generate
      for (gk = 0; gk < 4; gk++) begin : g_win
         assign rd_a_win_o[WIN_W-1-gk*BYTE_W -: BYTE_W] = mem_q[rd_a_base_i + ADDR_W'(gk)];
         assign rd_b_win_o[WIN_W-1-gk*BYTE_W -: BYTE_W] = mem_q[rd_b_base_i + ADDR_W'(gk)];
      end

      for (gi = 0; gi < FILE_BYTES; gi++) begin : g_byte
         logic [ADDR_W-1:0] off;
         logic              hit;
         logic [WIN_W-1:0]  sel;
         assign off = ADDR_W'(gi) - wr_base_i;
         assign hit = wr_en_i && (off < ADDR_W'(wr_nb_i));
         assign sel = wr_left << {off[1:0], 3'b000};
         always_ff @(posedge clk) begin
            if (!rst_n)
               mem_q[gi] <= '0;
            else if (hit)
               mem_q[gi] <= sel[WIN_W-1 -: BYTE_W];
            else if (ld_en_i && ld_addr_i == ADDR_W'(gi))
               mem_q[gi] <= ld_data_i;
         end
      end
   endgenerate

   assign pk_data_o = mem_q[pk_addr_i];

endmodule

// File: rtl/mw_alu_core.sv
module mw_alu_core
   import mw_alu_pkg::*;
#(
   parameter bit HAS_DIV = 1'b1
) (
   input  logic [OPC_W-1:0] op_i,
   input  logic [OPC_W-1:0] wid_i,
   input  logic [WIN_W-1:0] a_i,
   input  logic [WIN_W-1:0] b_i,
   input  flags_t           fl_i,
   output logic [WIN_W-1:0] res_o,
   output logic             wr_o,
   output logic             pair_o,
   output logic             fault_o,
   output flags_t           fl_o
);

   logic [WIN_W:0]   sum_w;
   logic [WIN_W-1:0] dif_w;
   logic [WIN_W-1:0] prod_w;
   logic [WIN_W-1:0] quo_w;
   logic [WIN_W-1:0] rem_w;
   logic             div_ok;
   logic [4:0]       top;
   logic [4:0]       dtop;
   logic [5:0]       cpos;
   logic [WIN_W-1:0] mask;
   logic             wid_bad;
   logic             is_dw;

   assign sum_w  = {1'b0, a_i} + {1'b0, b_i};
   assign dif_w  = a_i - b_i;
   assign prod_w = a_i * b_i;

   generate
      if (HAS_DIV) begin : g_div
         assign div_ok = (b_i != '0);
         assign quo_w  = div_ok ? (a_i / b_i) : '0;
         assign rem_w  = div_ok ? (a_i % b_i) : '0;
      end else begin : g_nodiv
         assign div_ok = 1'b0;
         assign quo_w  = '0;
         assign rem_w  = '0;
      end
   endgenerate

   always_comb begin
      wid_bad = 1'b0;
      top     = 5'd31;
      mask    = '1;
      case (wid_i)
         WD_BYTE:  begin top = 5'd7;  mask = 32'h0000_00FF; end
         WD_WORD:  begin top = 5'd15; mask = 32'h0000_FFFF; end
         WD_DWORD: begin top = 5'd31; mask = '1;            end
         default:  wid_bad = 1'b1;
      endcase
   end

   assign is_dw = (wid_i == WD_DWORD);
   assign dtop  = {top[3:0], 1'b1};
   assign cpos  = {1'b0, top} + 6'd1;

   always_comb begin
      fl_o    = fl_i;
      res_o   = '0;
      wr_o    = 1'b0;
      pair_o  = 1'b0;
      fault_o = 1'b0;
      case (op_i)
         OP_ADD: begin
            res_o   = sum_w[WIN_W-1:0] & mask;
            wr_o    = 1'b1;
            fl_o.cy = sum_w[cpos];
            fl_o.ov = (a_i[top] == b_i[top]) && (res_o[top] != a_i[top]);
            fl_o.z  = (res_o == '0);
            fl_o.n  = res_o[top];
         end
         OP_SUB, OP_CMP: begin
            res_o   = dif_w & mask;
            wr_o    = (op_i == OP_SUB);
            fl_o.cy = (a_i < b_i);
            fl_o.ov = (a_i[top] != b_i[top]) && (res_o[top] != a_i[top]);
            fl_o.z  = (res_o == '0);
            fl_o.n  = res_o[top];
         end
         OP_ANL, OP_ORL, OP_XRL: begin
            if (op_i == OP_ANL)      res_o = a_i & b_i;
            else if (op_i == OP_ORL) res_o = a_i | b_i;
            else                     res_o = a_i ^ b_i;
            wr_o   = 1'b1;
            fl_o.z = (res_o == '0);
            fl_o.n = res_o[top];
         end
         OP_MOV: begin
            res_o = b_i;
            wr_o  = 1'b1;
         end
         OP_MUL: begin
            if (is_dw) begin
               fault_o = 1'b1;
            end else begin
               res_o   = prod_w;
               wr_o    = 1'b1;
               pair_o  = 1'b1;
               fl_o.cy = 1'b0;
               fl_o.ov = 1'b0;
               fl_o.z  = (prod_w == '0);
               fl_o.n  = prod_w[dtop];
            end
         end
         OP_DIV: begin
            if (is_dw || !div_ok) begin
               fault_o = 1'b1;
            end else begin
               res_o   = (rem_w << cpos) | quo_w;
               wr_o    = 1'b1;
               pair_o  = 1'b1;
               fl_o.cy = 1'b0;
               fl_o.ov = 1'b0;
               fl_o.z  = (quo_w == '0);
               fl_o.n  = quo_w[top];
            end
         end
         default: fault_o = 1'b1;
      endcase
      if (wid_bad) begin
         fault_o = 1'b1;
         wr_o    = 1'b0;
         fl_o    = fl_i;
      end
   end

endmodule

// File: rtl/mw_reg_alu.sv
module mw_reg_alu
   import mw_alu_pkg::*;
#(
   parameter int FILE_BYTES = 64,
   parameter int DPX_BASE   = 56,
   parameter int SPX_BASE   = 60,
   parameter bit HAS_DIV    = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        issue_i,
   input  logic [3:0]  op_i,
   input  logic [3:0]  wid_i,
   input  logic [3:0]  dst_i,
   input  logic [3:0]  src_i,
   input  logic        ld_en_i,
   input  logic [5:0]  ld_addr_i,
   input  logic [7:0]  ld_data_i,
   input  logic [5:0]  pk_addr_i,
   output logic [7:0]  pk_data_o,
   output logic        done_o,
   output logic        err_o,
   output logic        cy_o,
   output logic        z_o,
   output logic        n_o,
   output logic        ov_o
);

   localparam int ADDR_W = $clog2(FILE_BYTES);

   generate
      if (FILE_BYTES != 64) begin : g_bad_file
         $error("mw_reg_alu: FILE_BYTES must be 64 to match the 6-bit load and peek ports");
      end
      if (DPX_BASE < 32 || DPX_BASE % 4 != 0 || DPX_BASE + 4 > FILE_BYTES) begin : g_bad_dpx
         $error("mw_reg_alu: DPX_BASE must be 4-aligned, above the general dwords and inside the file");
      end
      if (SPX_BASE < 32 || SPX_BASE % 4 != 0 || SPX_BASE + 4 > FILE_BYTES || SPX_BASE == DPX_BASE) begin : g_bad_spx
         $error("mw_reg_alu: SPX_BASE must be 4-aligned, distinct and inside the file");
      end
   endgenerate

   logic [ADDR_W-1:0] base_d, base_s, base_p;
   logic              ok_d, ok_s, ok_p;
   logic [WIN_W-1:0]  win_d, win_s;
   logic [WIN_W-1:0]  opa, opb;
   logic [4:0]        rshift;
   logic [2:0]        nb;
   logic [WIN_W-1:0]  res;
   logic              wr_req, pair, fault;
   flags_t            fl_q, fl_nxt;
   logic              bad;
   logic              wr_en;
   logic [ADDR_W-1:0] wr_base;
   logic [2:0]        wr_nb;
   logic              done_q, err_q;

   mw_idx_map #(.ADDR_W(ADDR_W), .DPX_BASE(DPX_BASE), .SPX_BASE(SPX_BASE)) u_map_d (
      .wid_i(wid_i), .idx_i(dst_i), .pair_i(1'b0), .base_o(base_d), .ok_o(ok_d));

   mw_idx_map #(.ADDR_W(ADDR_W), .DPX_BASE(DPX_BASE), .SPX_BASE(SPX_BASE)) u_map_s (
      .wid_i(wid_i), .idx_i(src_i), .pair_i(1'b0), .base_o(base_s), .ok_o(ok_s));

   mw_idx_map #(.ADDR_W(ADDR_W), .DPX_BASE(DPX_BASE), .SPX_BASE(SPX_BASE)) u_map_p (
      .wid_i(wid_i), .idx_i(dst_i), .pair_i(1'b1), .base_o(base_p), .ok_o(ok_p));

   always_comb begin
      case (wid_i)
         WD_BYTE:  begin nb = 3'd1; rshift = 5'd24; end
         WD_WORD:  begin nb = 3'd2; rshift = 5'd16; end
         WD_DWORD: begin nb = 3'd4; rshift = 5'd0;  end
         default:  begin nb = 3'd0; rshift = 5'd0;  end
      endcase
   end

   assign opa = win_d >> rshift;
   assign opb = win_s >> rshift;

   mw_alu_core #(.HAS_DIV(HAS_DIV)) u_core (
      .op_i(op_i), .wid_i(wid_i), .a_i(opa), .b_i(opb), .fl_i(fl_q),
      .res_o(res), .wr_o(wr_req), .pair_o(pair), .fault_o(fault), .fl_o(fl_nxt));

   assign bad     = fault || !ok_d || !ok_s || (pair && !ok_p);
   assign wr_en   = issue_i && wr_req && !bad;
   assign wr_base = pair ? base_p : base_d;
   assign wr_nb   = pair ? {nb[1:0], 1'b0} : nb;

   mw_regfile #(.FILE_BYTES(FILE_BYTES), .ADDR_W(ADDR_W)) u_rf (
      .clk(clk), .rst_n(rst_n),
      .rd_a_base_i(base_d), .rd_b_base_i(base_s),
      .rd_a_win_o(win_d), .rd_b_win_o(win_s),
      .wr_en_i(wr_en), .wr_base_i(wr_base), .wr_nb_i(wr_nb), .wr_data_i(res),
      .ld_en_i(ld_en_i), .ld_addr_i(ld_addr_i), .ld_data_i(ld_data_i),
      .pk_addr_i(pk_addr_i), .pk_data_o(pk_data_o));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fl_q   <= '0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         done_q <= issue_i;
         err_q  <= issue_i && bad;
         if (issue_i && !bad)
            fl_q <= fl_nxt;
      end
   end

   assign done_o = done_q;
   assign err_o  = err_q;
   assign cy_o   = fl_q.cy;
   assign z_o    = fl_q.z;
   assign n_o    = fl_q.n;
   assign ov_o   = fl_q.ov;

endmodule

// File: rtl/mw_reg_alu_chk.sv
module mw_reg_alu_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       issue_i,
   input logic [3:0] op_i,
   input logic       done_o,
   input logic       err_o,
   input logic       cy_o,
   input logic       z_o,
   input logic       n_o,
   input logic       ov_o
);

   // R10
   done_after_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(issue_i));

   // R11
   err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> done_o);

   // R11
   err_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> $stable({cy_o, z_o, n_o, ov_o}));

   // R7
   mov_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_i && op_i == 4'd7) |=> $stable({cy_o, z_o, n_o, ov_o}));

   // R6
   logic_keeps_cy_ov_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_i && (op_i == 4'd4 || op_i == 4'd5 || op_i == 4'd6)) |=> $stable({cy_o, ov_o}));

endmodule

bind mw_reg_alu mw_reg_alu_chk u_chk (
   .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .op_i(op_i),
   .done_o(done_o), .err_o(err_o), .cy_o(cy_o), .z_o(z_o), .n_o(n_o), .ov_o(ov_o));

// File: tb/tb_mw_reg_alu.sv
`timescale 1ns/100ps
module tb_mw_reg_alu;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       issue_i = 1'b0;
   logic [3:0] op_i = '0, wid_i = '0, dst_i = '0, src_i = '0;
   logic       ld_en_i = 1'b0;
   logic [5:0] ld_addr_i = '0;
   logic [7:0] ld_data_i = '0;
   logic [5:0] pk_addr_i = '0;
   logic [7:0] pk_data_o;
   logic       done_o, err_o, cy_o, z_o, n_o, ov_o;

   always #2.5 clk = ~clk;

   mw_reg_alu dut (
      .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .op_i(op_i), .wid_i(wid_i),
      .dst_i(dst_i), .src_i(src_i), .ld_en_i(ld_en_i), .ld_addr_i(ld_addr_i),
      .ld_data_i(ld_data_i), .pk_addr_i(pk_addr_i), .pk_data_o(pk_data_o),
      .done_o(done_o), .err_o(err_o), .cy_o(cy_o), .z_o(z_o), .n_o(n_o), .ov_o(ov_o));

   int nchk = 0, nfail = 0;
   logic [7:0] mem [64];
   bit ecy, ez, en, eov;

   task automatic check(input bit ok, input string tag, input string what, input longint act, input longint exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic int map_idx(input logic [3:0] w, input logic [3:0] i, input bit pr, output bit ok);
      ok = 1'b1;
      case (w)
         4'd12: return pr ? int'(i & 4'he) : int'(i);
         4'd13: return pr ? int'(i & 4'he) * 2 : int'(i) * 2;
         4'd15: begin
            if (i < 8) return int'(i) * 4;
            if (i == 8) return 56;
            if (i == 9) return 60;
            ok = 1'b0; return 0;
         end
         default: begin ok = 1'b0; return 0; end
      endcase
   endfunction

   function automatic logic [63:0] getv(input int base, input int nb);
      logic [63:0] v = '0;
      for (int k = 0; k < nb; k++) v = (v << 8) | 64'(mem[(base + k) % 64]);
      return v;
   endfunction

   task automatic putv(input int base, input int nb, input logic [63:0] v);
      for (int k = 0; k < nb; k++) mem[(base + k) % 64] = 8'(v >> (8 * (nb - 1 - k)));
   endtask

   task automatic model_exec(input logic [3:0] op, w, d, s, output bit e);
      int nb, bd, bs, bp, bits;
      bit okd, oks, okp;
      logic [63:0] a, b, r, msk, q, rm;
      e = 1'b0;
      nb = (w == 12) ? 1 : (w == 13) ? 2 : (w == 15) ? 4 : 0;
      bd = map_idx(w, d, 1'b0, okd);
      bs = map_idx(w, s, 1'b0, oks);
      bp = map_idx(w, d, 1'b1, okp);
      if (nb == 0 || !okd || !oks) e = 1'b1;
      if (!(op inside {4'd2, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9, 4'd10, 4'd11})) e = 1'b1;
      if ((op == 8 || op == 10) && nb == 4) e = 1'b1;
      if (e) return;
      bits = 8 * nb;
      msk = (64'd1 << bits) - 1;
      a = getv(bd, nb);
      b = getv(bs, nb);
      if (op == 8 && b == 0) begin e = 1'b1; return; end
      case (op)
         4'd2: begin
            r = a + b; ecy = r[bits]; r = r & msk;
            eov = (a[bits-1] == b[bits-1]) && (r[bits-1] != a[bits-1]);
            ez = (r == 0); en = r[bits-1]; putv(bd, nb, r);
         end
         4'd9, 4'd11: begin
            r = (a - b) & msk; ecy = (a < b);
            eov = (a[bits-1] != b[bits-1]) && (r[bits-1] != a[bits-1]);
            ez = (r == 0); en = r[bits-1];
            if (op == 9) putv(bd, nb, r);
         end
         4'd4, 4'd5, 4'd6: begin
            r = (op == 4) ? (a | b) : (op == 5) ? (a & b) : (a ^ b);
            ez = (r == 0); en = r[bits-1]; putv(bd, nb, r);
         end
         4'd7: putv(bd, nb, b);
         4'd10: begin
            r = a * b; ecy = 1'b0; eov = 1'b0;
            ez = (r == 0); en = r[2*bits-1]; putv(bp, 2 * nb, r);
         end
         default: begin
            q = a / b; rm = a % b; ecy = 1'b0; eov = 1'b0;
            ez = (q == 0); en = q[bits-1]; putv(bp, 2 * nb, (rm << bits) | q);
         end
      endcase
   endtask

   function automatic string tag_of(input logic [3:0] op, input bit e);
      if (e) return "R11";
      case (op)
         4'd2, 4'd9: return "R4";
         4'd11: return "R5";
         4'd4, 4'd5, 4'd6: return "R6";
         4'd7: return "R7";
         4'd10: return "R8";
         4'd8: return "R9";
         default: return "R1";
      endcase
   endfunction

   task automatic peek(input int a, output logic [7:0] v);
      pk_addr_i = 6'(a);
      #0.1;
      v = pk_data_o;
   endtask

   task automatic check_file(input string tag);
      logic [7:0] v;
      int bad = -1;
      logic [7:0] bv = '0;
      for (int i = 0; i < 64; i++) begin
         peek(i, v);
         if (v !== mem[i] && bad < 0) begin bad = i; bv = v; end
      end
      check(bad < 0, tag, $sformatf("file byte %0d", bad), bv, (bad < 0) ? 0 : mem[bad]);
   endtask

   task automatic load(input int a, input logic [7:0] v);
      @(negedge clk);
      ld_en_i = 1'b1; ld_addr_i = 6'(a); ld_data_i = v;
      @(negedge clk);
      ld_en_i = 1'b0;
      mem[a] = v;
   endtask

   task automatic run_op(input logic [3:0] op, w, d, s, input string extra);
      bit e;
      string tag;
      @(negedge clk);
      issue_i = 1'b1; op_i = op; wid_i = w; dst_i = d; src_i = s;
      model_exec(op, w, d, s, e);
      tag = (extra.len() > 0) ? extra : tag_of(op, e);
      @(negedge clk);
      issue_i = 1'b0;
      check(done_o === 1'b1 && err_o === e && {cy_o, z_o, n_o, ov_o} === {ecy, ez, en, eov},
            $sformatf("%s R10", tag), $sformatf("op %0d w %0d d %0d s %0d done/err/cy,z,n,ov", op, w, d, s),
            {done_o, err_o, cy_o, z_o, n_o, ov_o}, {1'b1, e, ecy, ez, en, eov});
      check_file(tag);
   endtask

   logic [3:0] ops [9] = '{4'd2, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9, 4'd10, 4'd11};

   initial begin
      logic [7:0] v;
      void'($urandom(32'd20251));
      for (int i = 0; i < 64; i++) mem[i] = '0;
      {ecy, ez, en, eov} = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 reset state
      check({done_o, err_o, cy_o, z_o, n_o, ov_o} === 6'b0, "R12", "reset outputs",
            {done_o, err_o, cy_o, z_o, n_o, ov_o}, 0);
      check_file("R12");

      // R12 load and peek
      load(0, 8'hFF); load(1, 8'h01);
      peek(0, v);
      check(v === 8'hFF, "R12", "peek after load", v, 8'hFF);

      // R4 byte add with carry out to zero
      run_op(4'd2, 4'd12, 4'd0, 4'd1, "R4");
      check(cy_o === 1'b1 && z_o === 1'b1, "R4", "ff+01 cy,z", {cy_o, z_o}, 2'b11);

      // R4 signed overflow
      load(2, 8'h7F); load(3, 8'h01);
      run_op(4'd2, 4'd12, 4'd2, 4'd3, "R4");
      check(ov_o === 1'b1 && n_o === 1'b1 && cy_o === 1'b0, "R4", "7f+01 ov,n,cy", {ov_o, n_o, cy_o}, 3'b110);

      // R5 compare with borrow, no write
      run_op(4'd11, 4'd12, 4'd3, 4'd2, "R5");
      check(cy_o === 1'b1, "R5", "cmp borrow", cy_o, 1);

      // R7 move keeps flags; R2 word index maps to byte pair
      run_op(4'd7, 4'd13, 4'd3, 4'd1, "R2");

      // R8 byte multiply into aligned pair
      load(2, 8'h12); load(3, 8'h34);
      run_op(4'd10, 4'd12, 4'd3, 4'd2, "R8");
      peek(2, v); check(v === 8'h03, "R8", "product high byte", v, 8'h03);
      peek(3, v); check(v === 8'hA8, "R8", "product low byte", v, 8'hA8);

      // R9 divide: even gets remainder, odd gets quotient
      load(4, 8'd100); load(5, 8'd7);
      run_op(4'd8, 4'd12, 4'd4, 4'd5, "R9");
      peek(4, v); check(v === 8'd2, "R9", "remainder", v, 2);
      peek(5, v); check(v === 8'd14, "R9", "quotient", v, 14);
      load(6, 8'd0);
      run_op(4'd8, 4'd12, 4'd4, 4'd6, "R9");

      // R3 dword 8 and 9 map to the extension registers; 10 is illegal
      for (int i = 56; i < 64; i++) load(i, 8'(i * 3 + 1));
      run_op(4'd7, 4'd15, 4'd0, 4'd8, "R3");
      run_op(4'd2, 4'd15, 4'd1, 4'd9, "R3");
      run_op(4'd7, 4'd15, 4'd10, 4'd0, "R3");
      run_op(4'd10, 4'd15, 4'd0, 4'd1, "R8");

      // R1 illegal op and width codes
      run_op(4'd3, 4'd12, 4'd0, 4'd1, "R1");
      run_op(4'd2, 4'd14, 4'd0, 4'd1, "R1");

      // random stimulus
      for (int n = 0; n < 400; n++) begin
         logic [3:0] op, w;
         int r;
         if (n % 25 == 0)
            for (int k = 0; k < 8; k++) load(int'($urandom % 64), 8'($urandom));
         r = int'($urandom % 10);
         w = (r < 4) ? 4'd12 : (r < 7) ? 4'd13 : (r < 9) ? 4'd15 : 4'($urandom);
         op = ($urandom % 12 == 0) ? 4'($urandom) : ops[$urandom % 9];
         run_op(op, w, 4'($urandom), 4'($urandom), "");
      end

      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

   initial begin
      #2_000_000;
      nchk++; nfail++;
      $display("FAIL R10 watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

endmodule